// File: doc/BRIEF.md
# Binary-Search Nonlinear Scale Solver

This block turns a one-dimensional importance profile into a per-position scale vector whose elements add up to a requested output length. Positions with high importance keep a scale of exactly 1.0. Low-importance positions absorb the change: they shrink below 1.0 when the output is shorter than the source, and they grow above 1.0 when it is longer. One solve handles one axis. The two axes of an image are solved one after the other, or by two instances.

The profile is written into an internal store through a simple write port, one 8-bit saliency value per position. A start pulse then launches a solve, carrying the profile length and the target length. The target is unsigned fixed point with 16 fraction bits.

The controller runs a bisection on a gain `alpha` in the interval [0, 1]. Each iteration walks the profile at one entry per cycle and accumulates the clipped scale sum. The solve stops when that sum lies within a small tolerance of the goal, or when an iteration limit is reached. A last walk writes the scale vector into an output store, which the consumer then reads by address.

Top module: `scale_solver`

## Requirements
- R1: After reset, `busy`, `done`, `converged` and `iterCount` are all 0.
- R2: At start, the target is compared with `profLen` scaled to 16 fraction bits. A smaller target selects mode code 1 (shrink), a larger one code 2 (grow), and an equal one code 0 (keep). The code appears on `mode`.
- R3: In shrink mode, the entry for saliency `s` is min(floor(alpha·s / 2^14), 65536), where `alpha` is the value on `alphaOut`. `alpha` is unsigned with 30 fraction bits. Entries are unsigned with 16 fraction bits, so 65536 means 1.0.
- R4: In grow mode, each entry is 131072 minus the R3 value for the same `alpha` and `s`. This bounds every entry to the range 1.0 to 2.0.
- R5: In keep mode, every entry is 65536, no search iteration runs (`iterCount` = 0), and `converged` is 1.
- R6: When `done` and `converged` are both 1, the sum of entries 0..profLen-1 differs from the target by at most 7 LSB (about 1.07e-4).
- R7: `iterCount` never exceeds 32. `converged` = 0 at `done` only when `iterCount` = 32.
- R8: A position with saliency 0 gets entry 0.0 in shrink mode and 2.0 (131072) in grow mode.
- R9: A start while idle raises `busy` at the next clock edge. `busy` and `done` are never high together. `done` rises when the output store is complete and stays high until the next accepted start.
- R10: A start pulse while `busy` is ignored. The mode, `alphaOut` and the result stay those of the running solve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| salWe | input | 1 | Write strobe for the profile store |
| salAddr | input | 9 | Profile store write address |
| salData | input | 8 | Saliency value to store |
| start | input | 1 | Launch a solve (taken only when idle) |
| profLen | input | 10 | Number of profile positions used, 1..512 |
| target | input | 27 | Target length, unsigned, 16 fraction bits |
| rdAddr | input | 9 | Output store read address |
| rdScale | output | 18 | Scale entry at `rdAddr`, 16 fraction bits |
| alphaOut | output | 31 | Final gain, 30 fraction bits |
| mode | output | 2 | 0 keep, 1 shrink, 2 grow |
| iterCount | output | 6 | Bisection iterations used |
| converged | output | 1 | Sum reached the tolerance |
| busy | output | 1 | Solve in progress |
| done | output | 1 | Result ready in the output store |

## Verification
The assertions assume three things about the inputs:
- `profLen` is at least 1.
- The target never exceeds twice the profile length.
- The profile store is left unchanged while `busy` is high.

The stimulus keeps to these. It also chooses goals that the clipped sum can reach: a shrink target no larger than the count of nonzero positions, and a grow target no smaller than twice the length minus that count.

Profiles in the swept cases have fewer than 16 positions. A single step of `alpha` then moves the sum by at most 15 LSB, so a goal inside reach always falls within the 7 LSB window, and convergence can be demanded. The long 512-entry case only checks the R3/R6/R7 relations, whichever way it terminates.

// File: rtl/scale_solver_pkg.sv
package scale_solver_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP   = 2'd0,
    MODE_SHRINK = 2'd1,
    MODE_GROW   = 2'd2
  } scaleMode_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadJob;    // latch length, goal, mode; reset bounds, index, sum
    logic clrIdx;     // rewind index and clear the running sum
    logic accStep;    // add current entry to the sum, advance index
    logic writeStep;  // write current entry to the output store, advance index
    logic goLow;      // sum below goal: lower bound takes the midpoint
    logic goHigh;     // sum above goal: upper bound takes the midpoint
  } solverCtl_t;

endpackage

// File: rtl/scale_solver_dp.sv
module scale_solver_dp
  import scale_solver_pkg::*;
#(
  parameter int MAX_LEN    = 512,
  parameter int SAL_W      = 8,
  parameter int FRAC       = 16,
  parameter int ALPHA_FRAC = 30,
  parameter int TOL_LSB    = 7,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int TGT_W   = LEN_W + 1 + FRAC,
  localparam int ENT_W   = FRAC + 2,
  localparam int ALPHA_W = ALPHA_FRAC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               salWe,
  input  logic [IDX_W-1:0]   salAddr,
  input  logic [SAL_W-1:0]   salData,
  input  logic [LEN_W-1:0]   profLen,
  input  logic [TGT_W-1:0]   target,
  input  solverCtl_t         ctl,
  input  logic [IDX_W-1:0]   rdAddr,
  output logic [ENT_W-1:0]   rdScale,
  output logic [ALPHA_W-1:0] alphaOut,
  output scaleMode_e         modeOut,
  output logic               lastIdx,
  output logic               withinTol,
  output logic               sumBelow,
  output logic               isKeep
);

  localparam int PROD_W = ALPHA_W + SAL_W;
  localparam int SHIFT  = ALPHA_FRAC - FRAC;
  localparam logic [PROD_W-1:0]  ONE_PROD  = PROD_W'(1) << ALPHA_FRAC;
  localparam logic [ALPHA_W-1:0] ONE_ALPHA = ALPHA_W'(1) << ALPHA_FRAC;
  localparam logic [ENT_W-1:0]   ONE_ENT   = ENT_W'(1) << FRAC;
  localparam logic [ENT_W-1:0]   TWO_ENT   = ENT_W'(2) << FRAC;
  localparam logic [TGT_W:0]     TOL_V     = (TGT_W + 1)'(TOL_LSB);

  logic [SAL_W-1:0]   profMem [MAX_LEN];
  logic [ENT_W-1:0]   outMem  [MAX_LEN];

  logic [LEN_W-1:0]   jobLen;
  logic [TGT_W-1:0]   goal;
  scaleMode_e         modeQ;
  logic [ALPHA_W-1:0] lo, hi;
  logic [IDX_W-1:0]   idx;
  logic [TGT_W-1:0]   acc;

  // bisection midpoint, stable for a whole walk
  logic [ALPHA_W:0]   boundSum;
  logic [ALPHA_W-1:0] mid;
  assign boundSum = {1'b0, lo} + {1'b0, hi};
  assign mid      = boundSum[ALPHA_W:1];

  // per-entry clipped scale
  logic [SAL_W-1:0]  curSal;
  logic [PROD_W-1:0] prod, prodShift;
  logic [ENT_W-1:0]  entryMin, entryOut;
  assign curSal    = profMem[idx];
  assign prod      = {{SAL_W{1'b0}}, mid} * {{ALPHA_W{1'b0}}, curSal};
  assign prodShift = prod >> SHIFT;
  assign entryMin  = (prod >= ONE_PROD) ? ONE_ENT : prodShift[ENT_W-1:0];

  always_comb begin
    unique case (modeQ)
      MODE_SHRINK: entryOut = entryMin;
      MODE_GROW:   entryOut = TWO_ENT - entryMin;
      default:     entryOut = ONE_ENT;
    endcase
  end

  // job setup: mode from target vs length; grow mode searches the mirrored goal
  logic [TGT_W-1:0] lenFix, twoLen;
  assign lenFix = TGT_W'(profLen) << FRAC;
  assign twoLen = lenFix << 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jobLen <= '0;
      goal   <= '0;
      modeQ  <= MODE_KEEP;
      lo     <= '0;
      hi     <= '0;
      idx    <= '0;
      acc    <= '0;
    end else begin
      if (ctl.loadJob) begin
        jobLen <= profLen;
        lo     <= '0;
        hi     <= ONE_ALPHA;
        idx    <= '0;
        acc    <= '0;
        if (target < lenFix) begin
          modeQ <= MODE_SHRINK;
          goal  <= target;
        end else if (target > lenFix) begin
          modeQ <= MODE_GROW;
          goal  <= twoLen - target;
        end else begin
          modeQ <= MODE_KEEP;
          goal  <= lenFix;
        end
      end
      if (ctl.clrIdx) begin
        idx <= '0;
        acc <= '0;
      end
      if (ctl.accStep) begin
        acc <= acc + TGT_W'(entryMin);
        idx <= idx + 1'b1;
      end
      if (ctl.writeStep) idx <= idx + 1'b1;
      if (ctl.goLow)  lo <= mid;
      if (ctl.goHigh) hi <= mid;
    end
  end

  always_ff @(posedge clk) begin
    if (salWe) profMem[salAddr] <= salData;
  end

  always_ff @(posedge clk) begin
    if (ctl.writeStep) outMem[idx] <= entryOut;
  end

  // status back to the controller
  logic signed [TGT_W:0] diff;
  logic [TGT_W:0]        absDiff;
  assign diff      = $signed({1'b0, acc}) - $signed({1'b0, goal});
  assign absDiff   = diff[TGT_W] ? (TGT_W + 1)'(-diff) : (TGT_W + 1)'(diff);
  assign withinTol = (absDiff <= TOL_V);
  assign sumBelow  = (acc < goal);
  assign lastIdx   = ((LEN_W'(idx) + LEN_W'(1)) == jobLen);
  assign isKeep    = (modeQ == MODE_KEEP);

  assign rdScale  = outMem[rdAddr];
  assign alphaOut = mid;
  assign modeOut  = modeQ;

endmodule

// File: rtl/scale_solver_ctrl.sv
module scale_solver_ctrl
  import scale_solver_pkg::*;
#(
  parameter int MAX_ITER = 32,
  localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              lastIdx,
  input  logic              withinTol,
  input  logic              sumBelow,
  input  logic              isKeep,
  output solverCtl_t        ctl,
  output logic [ITER_W-1:0] iterCount,
  output logic              converged,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_PASS, ST_DECIDE, ST_WRITE
  } ctrlState_e;

  ctrlState_e state, stateNxt;
  logic       lastIter;

  assign lastIter = (iterCount == ITER_W'(MAX_ITER - 1));

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.loadJob = 1'b1;
        stateNxt    = ST_INIT;
      end
      ST_INIT: stateNxt = isKeep ? ST_WRITE : ST_PASS;
      ST_PASS: begin
        ctl.accStep = 1'b1;
        if (lastIdx) stateNxt = ST_DECIDE;
      end
      ST_DECIDE: begin
        ctl.clrIdx = 1'b1;
        if (withinTol || lastIter) begin
          stateNxt = ST_WRITE;
        end else begin
          ctl.goLow  = sumBelow;
          ctl.goHigh = !sumBelow;
          stateNxt   = ST_PASS;
        end
      end
      ST_WRITE: begin
        ctl.writeStep = 1'b1;
        if (lastIdx) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      iterCount <= '0;
      converged <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= stateNxt;
      unique case (state)
        ST_IDLE: if (start) begin
          done      <= 1'b0;
          converged <= 1'b0;
          iterCount <= '0;
        end
        ST_INIT:   if (isKeep) converged <= 1'b1;
        ST_DECIDE: begin
          iterCount <= iterCount + 1'b1;
          if (withinTol) converged <= 1'b1;
        end
        ST_WRITE:  if (lastIdx) done <= 1'b1;
        default: ;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/scale_solver.sv
module scale_solver
  import scale_solver_pkg::*;
#(
  parameter int MAX_LEN    = 512,
  parameter int SAL_W      = 8,
  parameter int FRAC       = 16,
  parameter int ALPHA_FRAC = 30,
  parameter int MAX_ITER   = 32,
  parameter int TOL_LSB    = 7,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int TGT_W   = LEN_W + 1 + FRAC,
  localparam int ENT_W   = FRAC + 2,
  localparam int ALPHA_W = ALPHA_FRAC + 1,
  localparam int ITER_W  = $clog2(MAX_ITER + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               salWe,
  input  logic [IDX_W-1:0]   salAddr,
  input  logic [SAL_W-1:0]   salData,
  input  logic               start,
  input  logic [LEN_W-1:0]   profLen,
  input  logic [TGT_W-1:0]   target,
  input  logic [IDX_W-1:0]   rdAddr,
  output logic [ENT_W-1:0]   rdScale,
  output logic [ALPHA_W-1:0] alphaOut,
  output logic [1:0]         mode,
  output logic [ITER_W-1:0]  iterCount,
  output logic               converged,
  output logic               busy,
  output logic               done
);

  solverCtl_t ctl;
  scaleMode_e modeQ;
  logic       lastIdx, withinTol, sumBelow, isKeep;

  scale_solver_dp #(
    .MAX_LEN(MAX_LEN), .SAL_W(SAL_W), .FRAC(FRAC),
    .ALPHA_FRAC(ALPHA_FRAC), .TOL_LSB(TOL_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .salWe(salWe), .salAddr(salAddr), .salData(salData),
    .profLen(profLen), .target(target), .ctl(ctl),
    .rdAddr(rdAddr), .rdScale(rdScale), .alphaOut(alphaOut),
    .modeOut(modeQ), .lastIdx(lastIdx), .withinTol(withinTol),
    .sumBelow(sumBelow), .isKeep(isKeep)
  );

  scale_solver_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .lastIdx(lastIdx), .withinTol(withinTol), .sumBelow(sumBelow),
    .isKeep(isKeep), .ctl(ctl), .iterCount(iterCount),
    .converged(converged), .busy(busy), .done(done)
  );

  assign mode = modeQ;

endmodule

// File: rtl/scale_solver_chk.sv
module scale_solver_chk #(
  parameter int MAX_ITER   = 32,
  parameter int ALPHA_FRAC = 30,
  localparam int ITER_W  = $clog2(MAX_ITER + 1),
  localparam int ALPHA_W = ALPHA_FRAC + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               converged,
  input logic [ITER_W-1:0]  iterCount,
  input logic [1:0]         mode,
  input logic [ALPHA_W-1:0] alphaOut
);

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_iter_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= ITER_W'(MAX_ITER));

  p_cap_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !converged) |-> (iterCount == ITER_W'(MAX_ITER)));

  p_keep_noiter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 2'd0) |-> (iterCount == '0 && converged));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(mode));

  p_alpha_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(alphaOut));

endmodule

bind scale_solver scale_solver_chk #(.MAX_ITER(MAX_ITER), .ALPHA_FRAC(ALPHA_FRAC)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .converged(converged), .iterCount(iterCount), .mode(mode), .alphaOut(alphaOut)
);

// File: tb/scale_solver_bench.sv
module scale_solver_bench;

  localparam int  TOL    = 7;
  localparam int  CAP    = 32;
  localparam longint ONE = 65536;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        salWe = 1'b0;
  logic [8:0]  salAddr = '0;
  logic [7:0]  salData = '0;
  logic        start = 1'b0;
  logic [9:0]  profLen = '0;
  logic [26:0] target = '0;
  logic [8:0]  rdAddr = '0;
  logic [17:0] rdScale;
  logic [30:0] alphaOut;
  logic [1:0]  mode;
  logic [5:0]  iterCount;
  logic        converged, busy, done;

  int nChecks = 0;
  int nFails  = 0;
  int prof [512];

  always #5 clk = ~clk;

  scale_solver u_scale_solver (
    .clk(clk), .rstN(rstN), .salWe(salWe), .salAddr(salAddr), .salData(salData),
    .start(start), .profLen(profLen), .target(target), .rdAddr(rdAddr),
    .rdScale(rdScale), .alphaOut(alphaOut), .mode(mode), .iterCount(iterCount),
    .converged(converged), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint shrinkEnt(input longint a, input longint s);
    longint p = a * s;
    return (p >= (longint'(1) << 30)) ? ONE : (p >> 14);
  endfunction

  task automatic loadProfile(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      salWe = 1'b1; salAddr = 9'(k); salData = 8'(prof[k]);
    end
    @(negedge clk);
    salWe = 1'b0;
  endtask

  task automatic runCase(input int len, input longint tgt, input int expMode,
                         input bit needConv, input bit extraStart);
    longint sum = 0;
    longint ent, e, diff;
    int bad = 0, badZero = 0;
    @(negedge clk);
    profLen = 10'(len); target = 27'(tgt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    if (extraStart) begin
      repeat (5) @(negedge clk);
      target = 27'(2 * len * ONE - 3 * ONE); start = 1'b1;   // R10 stray start
      @(negedge clk);
      start = 1'b0; target = 27'(tgt);
    end
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0, "R9 busy low with done", busy, 0);
    check(int'(mode) == expMode, "R2 mode", mode, expMode);
    check(iterCount <= CAP && (converged || iterCount == CAP), "R7 iteration cap",
          iterCount, CAP);
    for (int k = 0; k < len; k++) begin
      rdAddr = 9'(k);
      #1;
      ent = longint'(rdScale);
      sum += ent;
      if (expMode == 0) e = ONE;
      else if (expMode == 1) e = shrinkEnt(longint'(alphaOut), prof[k]);
      else e = 2 * ONE - shrinkEnt(longint'(alphaOut), prof[k]);
      if (ent != e) begin
        bad++;
        if (bad == 1) $display("FAIL R3/R4/R5 entry %0d actual=%0d expected=%0d", k, ent, e);
      end
      if (prof[k] == 0 && expMode != 0 && ent != (expMode == 1 ? 0 : 2 * ONE)) badZero++;
    end
    check(bad == 0, (expMode == 0) ? "R5 keep entries" :
                    (expMode == 1) ? "R3 shrink entries" : "R4 grow entries", bad, 0);
    check(badZero == 0, "R8 zero-saliency entries", badZero, 0);
    if (expMode == 0) check(iterCount == 0, "R5 no iterations", iterCount, 0);
    if (needConv) check(converged === 1'b1, "R6 converged", converged, 1);
    if (converged) begin
      diff = sum - tgt;
      if (diff < 0) diff = -diff;
      check(diff <= TOL, "R6 sum within tolerance", sum, tgt);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !converged && iterCount == 0, "R1 reset state",
          {busy, done, converged, iterCount}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    // distinct saliency with one zero position, length 15
    for (int k = 0; k < 15; k++) prof[k] = (k == 5) ? 0 : 20 + 13 * k;
    loadProfile(15);
    for (int t = 1; t <= 14; t++) runCase(15, t * ONE, 1, 1'b1, 1'b0);   // R3 shrink sweep
    runCase(15, 15 * ONE, 0, 1'b1, 1'b0);                              // R5 keep
    for (int t = 16; t <= 29; t++) runCase(15, t * ONE, 2, 1'b1, 1'b0);  // R4 grow sweep
    runCase(15, 7 * ONE + 16384, 1, 1'b1, 1'b0);                        // R6 fractional target
    runCase(15, 20 * ONE + 49152, 2, 1'b1, 1'b0);
    runCase(15, 5 * ONE, 1, 1'b1, 1'b1);                                // R10 stray start

    // uniform saliency: every entry lands on the same value
    for (int k = 0; k < 12; k++) prof[k] = 100;
    loadProfile(12);
    runCase(12, 6 * ONE, 1, 1'b1, 1'b0);
    rdAddr = 9'd7; #1;
    check(rdScale == 18'd32768, "R3 uniform half scale", rdScale, 32768);
    runCase(12, 18 * ONE, 2, 1'b1, 1'b0);
    rdAddr = 9'd3; #1;
    check(rdScale == 18'd98304, "R4 uniform 1.5 scale", rdScale, 98304);

    // full-length profile
    for (int k = 0; k < 512; k++) prof[k] = (k * 7) % 256;
    loadProfile(512);
    runCase(512, 100 * ONE, 1, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule